// File: doc/BRIEF.md
# Four-Beat Burst Address Sequencer

This block turns a single starting word address into the four word addresses of a short burst. An access starts when one of two active-low address strobes is recognised while the device is selected. One strobe comes from a processor and the other from a cache controller. On that edge the upper address bits are held in a register, and the two low bits become the start of a 2-bit burst sequence. On later edges the advance input steps the low bits through the burst, or holds them to suspend it. The low bits wrap back to the start value after the fourth beat, and the upper bits never move.

A static order select chooses the stepping rule. Linear order adds one to the low bits modulo four. Interleaved order forms the start value XOR a running beat count. The processor strobe has priority over the controller strobe, and it is gated by the first chip enable alone. A flag records which strobe started the current burst, so that downstream write logic can tell the two apart. The memory array, the write-enable decode and the data path belong to neighbouring blocks.

Top module: `burst_addr_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets `word_addr` to zero and `ctrl_started` to 0. The first beat after reset is therefore address 0.
- R2: If `proc_stb_n`=0 and the device is selected at a rising edge, a load occurs and `word_addr` equals `addr_in` after that edge. The device is selected when `ce_a_n`=0, `ce_b`=1 and `ce_c_n`=0.
- R3: If `ctrl_stb_n`=0 and the device is selected, a load occurs. After a load started by the controller strobe alone, `ctrl_started` is 1. After a load started by the processor strobe, it is 0.
- R4: If both strobes are low on the same edge, only the processor strobe is recognised, so `ctrl_started` is 0 after the load.
- R5: While `ce_a_n`=1, the processor strobe is ignored. With `ctrl_stb_n`=1 as well, that edge behaves as if no strobe were present: `adv_n`=0 advances and `adv_n`=1 holds.
- R6: If a strobe is recognised but the device is not selected, nothing is loaded and nothing advances. `word_addr` and `ctrl_started` keep their values.
- R7: With no strobe recognised, `adv_n`=0 at a rising edge moves the low two bits of `word_addr` to the next beat.
- R8: With no strobe recognised, `adv_n`=1 leaves `word_addr` unchanged, which suspends the burst.
- R9: With `order_sel`=1 (interleaved), the low two bits on beat k (k = 0..3) are the start value XOR k. For example, a start of 10 gives 10, 11, 00, 01.
- R10: With `order_sel`=0 (linear), the low two bits on beat k are (start + k) mod 4. For example, a start of 01 gives 01, 10, 11, 00. In both orders, a fifth beat returns to the start value.
- R11: `adv_n` has no effect on a load edge. Right after a load, the low bits equal the low bits of `addr_in`.
- R12: Bits above bit 1 of `word_addr` change only on a load or a reset. A wrap of the low bits never carries into them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| proc_stb_n | input | 1 | Processor address strobe, active low |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| ce_a_n | input | 1 | First chip enable, active low; also gates the processor strobe |
| ce_b | input | 1 | Second chip enable, active high |
| ce_c_n | input | 1 | Third chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved; static |
| addr_in | input | ADDR_W | Word address offered with a strobe |
| word_addr | output | ADDR_W | Current word address to the array |
| ctrl_started | output | 1 | 1 if the current burst was loaded by the controller strobe |

## Verification
The hardest condition to reach is a processor strobe made invisible by the first chip enable while the controller strobe is idle. In that state the edge must act as a plain advance or suspend, not as a deselect. The stimulus reaches it right after a burst has reached beat 3, so an advance wraps the low bits to a value that differs from both a hold and a reload. The two deselect forms are also driven: an enable dropped under a controller strobe, and an enable dropped under a recognised processor strobe. After each one, the bench confirms that the address and the start flag are unchanged.

// File: rtl/bseq_pkg.sv
package bseq_pkg;
  localparam int BEAT_W = 2;

  typedef enum logic {
    ORD_LINEAR = 1'b0,
    ORD_XOR    = 1'b1
  } order_e;

  typedef logic [BEAT_W-1:0] beat_t;

  // Low address bits for a given start value and beat count.
  function automatic beat_t step_low(beat_t start, beat_t beat, order_e ord);
    beat_t r;
    if (ord == ORD_XOR) r = start ^ beat;
    else                r = beat_t'(start + beat);
    return r;
  endfunction
endpackage

// File: rtl/bseq_strobe_decode.sv
module bseq_strobe_decode (
  input  logic proc_stb_n,
  input  logic ctrl_stb_n,
  input  logic ce_a_n,
  input  logic ce_b,
  input  logic ce_c_n,
  input  logic adv_n,
  output logic strobe_seen,
  output logic sel_ok,
  output logic load_evt,
  output logic load_ctrl,
  output logic adv_evt
);
  logic proc_take;
  logic ctrl_req;

  always_comb begin
    // processor strobe only counts while the first enable is active
    proc_take   = !proc_stb_n && !ce_a_n;
    ctrl_req    = !ctrl_stb_n;
    strobe_seen = proc_take || ctrl_req;
    sel_ok      = !ce_a_n && ce_b && !ce_c_n;
    load_evt    = strobe_seen && sel_ok;
    // processor wins when both are present
    load_ctrl   = load_evt && !proc_take;
    adv_evt     = !strobe_seen && !adv_n;
  end
endmodule

// File: rtl/bseq_burst_counter.sv
module bseq_burst_counter
  import bseq_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load_evt,
  input  logic   adv_evt,
  input  beat_t  load_low,
  input  order_e ord,
  output beat_t  low_out
);
  beat_t start_q;
  beat_t beat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      start_q <= '0;
      beat_q  <= '0;
    end else if (load_evt) begin
      start_q <= load_low;
      beat_q  <= '0;
    end else if (adv_evt) begin
      beat_q  <= beat_q + 1'b1;
    end
  end

  always_comb low_out = step_low(start_q, beat_q, ord);

  AST_LOAD_SETS_START: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> (!$stable(ord) || low_out == $past(load_low))); // R11
endmodule

// File: rtl/bseq_addr_register.sv
module bseq_addr_register #(
  parameter int UP_W = 15
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            load_evt,
  input  logic            load_ctrl,
  input  logic [UP_W-1:0] up_in,
  output logic [UP_W-1:0] up_q,
  output logic            ctrl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      up_q   <= '0;
      ctrl_q <= 1'b0;
    end else if (load_evt) begin
      up_q   <= up_in;
      ctrl_q <= load_ctrl;
    end
  end

  AST_UPPER_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_evt |=> $stable(up_q)); // R12
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import bseq_pkg::*;
#(
  parameter int ADDR_W = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              proc_stb_n,
  input  logic              ctrl_stb_n,
  input  logic              ce_a_n,
  input  logic              ce_b,
  input  logic              ce_c_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] word_addr,
  output logic              ctrl_started
);
  localparam int UP_W = ADDR_W - BEAT_W;

  logic      strobe_seen;
  logic      sel_ok;
  logic      load_evt;
  logic      load_ctrl;
  logic      adv_evt;
  logic [UP_W-1:0] up_q;
  beat_t     low_q;
  order_e    ord;

  always_comb ord = order_e'(order_sel);

  bseq_strobe_decode u_dec (
    .proc_stb_n (proc_stb_n),
    .ctrl_stb_n (ctrl_stb_n),
    .ce_a_n     (ce_a_n),
    .ce_b       (ce_b),
    .ce_c_n     (ce_c_n),
    .adv_n      (adv_n),
    .strobe_seen(strobe_seen),
    .sel_ok     (sel_ok),
    .load_evt   (load_evt),
    .load_ctrl  (load_ctrl),
    .adv_evt    (adv_evt)
  );

  bseq_burst_counter u_cnt (
    .clk     (clk),
    .rst     (rst),
    .load_evt(load_evt),
    .adv_evt (adv_evt),
    .load_low(addr_in[BEAT_W-1:0]),
    .ord     (ord),
    .low_out (low_q)
  );

  bseq_addr_register #(.UP_W(UP_W)) u_areg (
    .clk      (clk),
    .rst      (rst),
    .load_evt (load_evt),
    .load_ctrl(load_ctrl),
    .up_in    (addr_in[ADDR_W-1:BEAT_W]),
    .up_q     (up_q),
    .ctrl_q   (ctrl_started)
  );

  always_comb word_addr = {up_q, low_q};

  AST_LOAD_ADDR: assert property (@(posedge clk) disable iff (rst)
    load_evt |=> (!$stable(order_sel) || word_addr == $past(addr_in))); // R2

  AST_CTRL_FLAG: assert property (@(posedge clk) disable iff (rst)
    (proc_stb_n && !ctrl_stb_n && sel_ok) |=> ctrl_started); // R3

  AST_PROC_PRIORITY: assert property (@(posedge clk) disable iff (rst)
    (!proc_stb_n && !ctrl_stb_n && sel_ok) |=> !ctrl_started); // R4

  AST_PROC_GATED: assert property (@(posedge clk) disable iff (rst)
    (!proc_stb_n && ce_a_n && ctrl_stb_n && adv_n)
      |=> (!$stable(order_sel) || $stable(word_addr))); // R5

  AST_DESELECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (strobe_seen && !sel_ok)
      |=> ($stable(ctrl_started) && (!$stable(order_sel) || $stable(word_addr)))); // R6

  AST_ADV_MOVES: assert property (@(posedge clk) disable iff (rst)
    adv_evt |=> (!$stable(order_sel) ||
                 word_addr[BEAT_W-1:0] != $past(word_addr[BEAT_W-1:0]))); // R7

  AST_SUSPEND_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!strobe_seen && adv_n) |=> (!$stable(order_sel) || $stable(word_addr))); // R8
endmodule

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 17;

  typedef struct packed {
    logic          p_n;
    logic          c_n;
    logic          ea_n;
    logic          eb;
    logic          ec_n;
    logic          adv_n;
    logic          ord;
    logic [AW-1:0] addr;
    logic [AW-1:0] exp_addr;
    logic          exp_ctl;
    logic [3:0]    req;
  } vec_t;

  localparam int NV = 20;
  // fields: p_n c_n ea_n eb ec_n adv_n ord addr exp_addr exp_ctl req
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,17'h0A5C6,17'h0A5C6,1'b0,4'd11}, // R2 R11 load, adv ignored
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,17'h1FFFF,17'h0A5C7,1'b0,4'd9},  // R9 10^01
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,17'h1FFFF,17'h0A5C4,1'b0,4'd9},  // R9 10^10
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,17'h1FFFF,17'h0A5C4,1'b0,4'd8},  // R8 suspend
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,17'h1FFFF,17'h0A5C5,1'b0,4'd9},  // R9 10^11
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,17'h1FFFF,17'h0A5C6,1'b0,4'd10}, // R10 wrap to start
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,17'h13579,17'h13579,1'b1,4'd3},  // R3 controller load
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,17'h00000,17'h1357A,1'b1,4'd10}, // R10 linear 10
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,17'h00000,17'h1357B,1'b1,4'd10}, // R10 linear 11
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,17'h00000,17'h13578,1'b1,4'd12}, // R12 no carry up
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,17'h00000,17'h13579,1'b1,4'd10}, // R10 back to start
    '{1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,17'h00003,17'h00003,1'b0,4'd4},  // R4 both strobes
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,1'b0,17'h1FFFF,17'h00000,1'b0,4'd5},  // R5 gated, advances
    '{1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,17'h1FFFF,17'h00000,1'b0,4'd5},  // R5 gated, holds
    '{1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,17'h1FFFF,17'h00000,1'b0,4'd6},  // R6 second enable off
    '{1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,17'h1FFFF,17'h00000,1'b0,4'd6},  // R6 third enable off
    '{1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,17'h1FFFF,17'h00000,1'b0,4'd6},  // R6 first enable off
    '{1'b1,1'b0,1'b0,1'b1,1'b0,1'b1,1'b1,17'h0FFFE,17'h0FFFE,1'b1,4'd3},  // R3 controller load
    '{1'b1,1'b1,1'b0,1'b1,1'b0,1'b0,1'b1,17'h00000,17'h0FFFF,1'b1,4'd7},  // R7 advance
    '{1'b0,1'b1,1'b0,1'b1,1'b0,1'b1,1'b1,17'h00001,17'h00001,1'b0,4'd2}   // R2 processor load
  };

  logic          clk = 1'b0;
  logic          rst;
  logic          proc_stb_n, ctrl_stb_n, ce_a_n, ce_b, ce_c_n, adv_n, order_sel;
  logic [AW-1:0] addr_in;
  logic [AW-1:0] word_addr;
  logic          ctrl_started;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst),
    .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n),
    .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
    .adv_n(adv_n), .order_sel(order_sel),
    .addr_in(addr_in), .word_addr(word_addr), .ctrl_started(ctrl_started)
  );

  task automatic check(input logic [AW-1:0] ea, input logic ec, input int req);
    checks++;
    if (word_addr !== ea || ctrl_started !== ec) begin
      errors++;
      $display("FAIL R%0d: word_addr=%h ctrl_started=%b, expected %h %b",
               req, word_addr, ctrl_started, ea, ec);
    end
  endtask

  task automatic idle();
    proc_stb_n = 1'b1; ctrl_stb_n = 1'b1;
    ce_a_n = 1'b0; ce_b = 1'b1; ce_c_n = 1'b0;
    adv_n = 1'b1; addr_in = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    idle();
    order_sel = 1'b1;
    rst = 1'b1;
    repeat (3) tick();
    check('0, 1'b0, 1);                          // R1 reset state
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      proc_stb_n = VECS[i].p_n;  ctrl_stb_n = VECS[i].c_n;
      ce_a_n     = VECS[i].ea_n; ce_b       = VECS[i].eb;
      ce_c_n     = VECS[i].ec_n; adv_n      = VECS[i].adv_n;
      order_sel  = VECS[i].ord;  addr_in    = VECS[i].addr;
      tick();
      check(VECS[i].exp_addr, VECS[i].exp_ctl, int'(VECS[i].req));
    end

    // R1: reset in mid burst clears address and start flag
    idle();
    ctrl_stb_n = 1'b0; addr_in = 17'h1ABCD;
    tick();
    ctrl_stb_n = 1'b1; adv_n = 1'b0;
    tick();
    rst = 1'b1; adv_n = 1'b1;
    tick();
    check('0, 1'b0, 1);                          // R1
    rst = 1'b0;

    // R10: linear advance from the reset state
    order_sel = 1'b0; adv_n = 1'b0;
    tick();
    check(17'h00001, 1'b0, 10);                  // R10

    // R11: load with advance requested keeps start value (linear)
    proc_stb_n = 1'b0; addr_in = 17'h05553; adv_n = 1'b0;
    tick();
    check(17'h05553, 1'b0, 11);                  // R11
    proc_stb_n = 1'b1;
    tick();
    check(17'h05550, 1'b0, 10);                  // R10 11+1 wraps to 00
    idle();

    done = 1'b1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule